// File: doc/BRIEF.md
# Bitwise Ternary Lookup Unit

This unit applies a programmable three-input Boolean function to every bit position of three XLEN-bit operands at once. Each bit position works like a small 3-input lookup table. At each position, one bit from the current destination value, one from the first source and one from the second source are combined into a 3-bit index. That index picks one entry from an 8-entry truth table. The truth table can come from an immediate, which arrives as two split fields, or from the low byte of a fourth register operand. Because the old destination value is one of the three inputs, a single operation can express any bitwise mix, select, majority or parity of the three values.

A masked variant writes only the bytes that a 4-bit mask enables. Every other byte of the destination keeps its old value. A fourth mode code leaves the destination unchanged.

The operands are sampled on a rising clock edge. The result appears from a register one cycle later.

Top module: `tern_lut_unit`

## Requirements
- R1: For every bit position i, the lookup index is `{rt_old[i], src_a[i], src_b[i]}`, with rt_old as the most significant index bit and src_b as the least significant. The result bit is entry `index` of the 8-bit table, where entry 0 is table bit 0.
- R2: In immediate mode (`op_mode` = 2'b00), the table is `{tbl_hi, tbl_lo}`. Entries 0 to 4 come from `tbl_lo[4:0]` and entries 5 to 7 come from `tbl_hi[2:0]`.
- R3: In register mode (`op_mode` = 2'b01), the table is `src_c[7:0]`. Bits of `src_c` above bit 7 have no effect on the result.
- R4: In masked mode (`op_mode` = 2'b10), the table is the immediate table. If `byte_en[j]` is 1, byte j of the result (bits 8j to 8j+7) is the lookup result. If `byte_en[j]` is 0, that byte equals byte j of `rt_old`.
- R5: In masked mode, bytes 4 and above (bit 32 upward) always equal `rt_old`, whatever the mask.
- R6: Mode code 2'b11 makes the result equal to `rt_old` in full.
- R7: The result for the inputs sampled at one rising edge is visible on `result` after that edge and holds until the next edge.
- R8: A rising edge with `rst_n` low clears `result` to zero.
- R9: Table 0x96 yields the bitwise XOR of the three inputs. Table 0xE8 yields their bitwise majority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode | input | 2 | 00 immediate, 01 register table, 10 masked, 11 hold |
| tbl_lo | input | 5 | Immediate table entries 0 to 4 |
| tbl_hi | input | 3 | Immediate table entries 5 to 7 |
| byte_en | input | 4 | Byte write enables for masked mode |
| rt_old | input | XLEN | Current destination value, also the index MSB |
| src_a | input | XLEN | First source, index middle bit |
| src_b | input | XLEN | Second source, index LSB |
| src_c | input | XLEN | Register table source (low 8 bits used) |
| result | output | XLEN | Registered new destination value |

## Verification
In masked mode, two things happen to the destination in the same cycle. Enabled bytes take the lookup result, and disabled bytes pass the old value through. The bench provokes this with mixed masks. It uses tables whose outputs differ from `rt_old` in every byte, so a wrong lane choice always shows up. It also changes mode on every clock, so that a table source or a mask left over from the previous operation would corrupt the next one. Each registered result is judged against a behavioural per-bit model that is evaluated one cycle earlier.

// File: rtl/tlu_pkg.sv
// Package: shared mode encoding and table width for the ternary lookup unit.
package tlu_pkg;
    typedef enum logic [1:0] {
        TLU_IMM  = 2'b00,
        TLU_REG  = 2'b01,
        TLU_MASK = 2'b10,
        TLU_HOLD = 2'b11
    } tlu_mode_e;

    localparam int TBL_W = 8;
    localparam int LO_W  = 5;
    localparam int HI_W  = TBL_W - LO_W;
endpackage

// File: rtl/tlu_table_sel.sv
// Module: chooses the 8-entry truth table from the split immediate fields
// or the low byte of the register table operand.
// Assumes: the immediate low field holds entries 0..LO_W-1.
module tlu_table_sel
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  tlu_mode_e          mode_i,
    input  logic [LO_W-1:0]    tbl_lo_i,
    input  logic [HI_W-1:0]    tbl_hi_i,
    input  logic [XLEN-1:0]    src_c_i,
    output logic [TBL_W-1:0]   table_o
);
    logic [TBL_W-1:0] imm_tbl;

    // Join the two immediate fields into one table.
    always_comb imm_tbl = {tbl_hi_i, tbl_lo_i};

    // Register mode reads the low byte of src_c; every other mode uses the immediate.
    always_comb begin
        if (mode_i == TLU_REG) table_o = src_c_i[TBL_W-1:0];
        else                   table_o = imm_tbl;
    end
endmodule

// File: rtl/tlu_lut_bank.sv
// Module: one 3-input lookup per bit position, all positions in parallel.
// Assumes: index MSB is rt, middle is a, LSB is b; table bit 0 is entry 0.
module tlu_lut_bank
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [TBL_W-1:0] table_i,
    input  logic [XLEN-1:0]  rt_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    output logic [XLEN-1:0]  lut_o
);
    localparam int IDX_W = $clog2(TBL_W);

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        logic [IDX_W-1:0] idx;
        // Build the index for this bit and look it up in the table.
        always_comb begin
            idx      = {rt_i[i], a_i[i], b_i[i]};
            lut_o[i] = table_i[idx];
        end
    end
endmodule

// File: rtl/tlu_lane_merge.sv
// Module: per-byte choice between the lookup result and the old destination.
// Assumes: XLEN is a multiple of LANE_W; bytes at or above MASK_W are never
// written in masked mode.
module tlu_lane_merge
    import tlu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int MASK_W = 4,
    parameter int LANE_W = 8
) (
    input  tlu_mode_e          mode_i,
    input  logic [MASK_W-1:0]  mask_i,
    input  logic [XLEN-1:0]    lut_i,
    input  logic [XLEN-1:0]    rt_i,
    output logic [XLEN-1:0]    merged_o
);
    localparam int NLANES = XLEN / LANE_W;

    logic [NLANES-1:0] lane_we;

    for (genvar j = 0; j < NLANES; j++) begin : g_lane
        if (j < MASK_W) begin : g_masked
            // A lane the mask covers: written when enabled, or in any full-write mode.
            always_comb begin
                unique case (mode_i)
                    TLU_IMM, TLU_REG: lane_we[j] = 1'b1;
                    TLU_MASK:         lane_we[j] = mask_i[j];
                    default:          lane_we[j] = 1'b0;
                endcase
            end
        end else begin : g_unmasked
            // A lane above the mask: written only in the full-write modes.
            always_comb lane_we[j] = (mode_i == TLU_IMM) || (mode_i == TLU_REG);
        end
        // Select the new or the old byte for this lane.
        always_comb merged_o[j*LANE_W +: LANE_W] =
            lane_we[j] ? lut_i[j*LANE_W +: LANE_W] : rt_i[j*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/tern_lut_unit.sv
// Module: top of the ternary lookup unit. Selects the table, runs the
// per-bit lookups, merges lanes and registers the result.
// Assumes: synchronous active-low reset; XLEN a multiple of 8 and >= 32.
module tern_lut_unit
    import tlu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_mode,
    input  logic [LO_W-1:0]   tbl_lo,
    input  logic [HI_W-1:0]   tbl_hi,
    input  logic [MASK_W-1:0] byte_en,
    input  logic [XLEN-1:0]   rt_old,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [XLEN-1:0]   src_c,
    output logic [XLEN-1:0]   result
);
    localparam int LANE_W = 8;

    tlu_mode_e        mode_e;
    logic [TBL_W-1:0] table_w;
    logic [XLEN-1:0]  lut_w;
    logic [XLEN-1:0]  merged_w;

    // Interpret the raw mode code as the package enum.
    always_comb mode_e = tlu_mode_e'(op_mode);

    tlu_table_sel #(.XLEN(XLEN)) u_table_sel (
        .mode_i   (mode_e),
        .tbl_lo_i (tbl_lo),
        .tbl_hi_i (tbl_hi),
        .src_c_i  (src_c),
        .table_o  (table_w)
    );

    tlu_lut_bank #(.XLEN(XLEN)) u_lut_bank (
        .table_i (table_w),
        .rt_i    (rt_old),
        .a_i     (src_a),
        .b_i     (src_b),
        .lut_o   (lut_w)
    );

    tlu_lane_merge #(.XLEN(XLEN), .MASK_W(MASK_W), .LANE_W(LANE_W)) u_lane_merge (
        .mode_i   (mode_e),
        .mask_i   (byte_en),
        .lut_i    (lut_w),
        .rt_i     (rt_old),
        .merged_o (merged_w)
    );

    // Register the merged value; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= merged_w;
    end

    // Reset clears the output register (R8).
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (result == '0));

    // Hold mode returns the old destination (R6).
    p_hold_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b11) |=> (result == $past(rt_old)));

    // Masked mode with no lanes enabled leaves the destination alone (R4).
    p_mask_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b10 && byte_en == '0) |=> (result == $past(rt_old)));

    // Masked mode never changes bytes above the mask (R5).
    p_mask_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b10) |=>
        (result[XLEN-1:MASK_W*LANE_W] == $past(rt_old[XLEN-1:MASK_W*LANE_W])));

    // An all-zero immediate table gives zero in immediate mode (R2).
    p_imm_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b00 && tbl_lo == '0 && tbl_hi == '0) |=> (result == '0));

    // An all-ones register table gives all ones in register mode (R3).
    p_reg_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b01 && src_c[TBL_W-1:0] == '1) |=> (result == '1));
endmodule

// File: tb/tern_lut_unit_bench.sv
`timescale 1ns/1ps
module tern_lut_unit_bench;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      op_mode = 2'b00;
    logic [4:0]      tbl_lo = '0;
    logic [2:0]      tbl_hi = '0;
    logic [3:0]      byte_en = '0;
    logic [XLEN-1:0] rt_old = '0, src_a = '0, src_b = '0, src_c = '0;
    logic [XLEN-1:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    tern_lut_unit u_tern_lut_unit (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .tbl_lo(tbl_lo),
        .tbl_hi(tbl_hi), .byte_en(byte_en), .rt_old(rt_old), .src_a(src_a),
        .src_b(src_b), .src_c(src_c), .result(result)
    );

    // Behavioural model written from the requirements.
    function automatic logic [XLEN-1:0] model(input logic [1:0] m,
            input logic [7:0] imm, input logic [3:0] en,
            input logic [XLEN-1:0] t, input logic [XLEN-1:0] a,
            input logic [XLEN-1:0] b, input logic [XLEN-1:0] c);
        logic [XLEN-1:0] r;
        logic [7:0] tb;
        tb = (m == 2'b01) ? c[7:0] : imm;
        for (int i = 0; i < XLEN; i++) begin
            int idx;
            bit wr;
            idx = int'(t[i]) * 4 + int'(a[i]) * 2 + int'(b[i]);
            case (m)
                2'b00, 2'b01: wr = 1;
                2'b10:        wr = (i / 8 < 4) ? bit'(en[i / 8]) : 0;
                default:      wr = 0;
            endcase
            r[i] = wr ? tb[idx] : t[i];
        end
        return r;
    endfunction

    task automatic compare(input logic [XLEN-1:0] exp, input string req);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, result, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic op(input logic [1:0] m, input logic [7:0] imm,
            input logic [3:0] en, input logic [XLEN-1:0] t,
            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
            input logic [XLEN-1:0] c, input string req);
        logic [XLEN-1:0] exp;
        op_mode = m; tbl_lo = imm[4:0]; tbl_hi = imm[7:5]; byte_en = en;
        rt_old = t; src_a = a; src_b = b; src_c = c;
        exp = model(m, imm, en, t, a, b, c);
        @(negedge clk);
        compare(exp, req);
    endtask

    function automatic logic [XLEN-1:0] rnd();
        return {$urandom(), $urandom()};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] t, a, b;
        repeat (3) @(negedge clk);
        // R8: reset state
        compare('0, "R8 reset");
        rst_n = 1'b1;

        // R9: parity and majority, also checked against direct formulas
        for (int k = 0; k < 6; k++) begin
            t = rnd(); a = rnd(); b = rnd();
            op(2'b00, 8'h96, 4'h0, t, a, b, rnd(), "R9 xor3 model");
            compare(t ^ a ^ b, "R9 xor3 direct");
            op(2'b00, 8'hE8, 4'h0, t, a, b, rnd(), "R9 majority model");
            compare((t & a) | (t & b) | (a & b), "R9 majority direct");
        end

        // R1: single-entry tables pick out exactly one index pattern
        for (int e = 0; e < 8; e++) begin
            op(2'b00, 8'(1 << e), 4'h0, rnd(), rnd(), rnd(), '0, "R1 index order");
        end
        // R1: distinct table per index bit to expose operand swaps
        op(2'b00, 8'hF0, 4'h0, rnd(), rnd(), rnd(), '0, "R1 rt is msb");
        op(2'b00, 8'hCC, 4'h0, rnd(), rnd(), rnd(), '0, "R1 src_a middle");
        op(2'b00, 8'hAA, 4'h0, rnd(), rnd(), rnd(), '0, "R1 src_b lsb");

        // R2: split immediate fields
        op(2'b00, 8'h1F, 4'h0, rnd(), rnd(), rnd(), '0, "R2 low field");
        op(2'b00, 8'hE0, 4'h0, rnd(), rnd(), rnd(), '0, "R2 high field");
        op(2'b00, 8'h00, 4'h0, rnd(), rnd(), rnd(), '1, "R2 zero table");

        // R3: register table, upper src_c bits garbage
        for (int k = 0; k < 10; k++) begin
            op(2'b01, 8'($urandom()), 4'h0, rnd(), rnd(), rnd(), rnd(), "R3 reg table");
        end
        op(2'b01, 8'hFF, 4'h0, rnd(), rnd(), rnd(), {56'hFFFF_FFFF_FFFF_FF, 8'h00}, "R3 upper ignored");

        // R4/R5: masked writes with every mask, table inverts rt
        for (int mk = 0; mk < 16; mk++) begin
            op(2'b10, 8'h0F, 4'(mk), rnd(), rnd(), rnd(), rnd(), "R4 mask lanes");
            op(2'b10, 8'($urandom()), 4'(mk), rnd(), rnd(), rnd(), rnd(), "R5 upper lanes kept");
        end

        // R6: hold mode
        for (int k = 0; k < 4; k++) begin
            op(2'b11, 8'($urandom()), 4'hF, rnd(), rnd(), rnd(), '1, "R6 hold");
        end

        // R7: mode changes every cycle, compared each clock
        for (int k = 0; k < 200; k++) begin
            op(2'($urandom()), 8'($urandom()), 4'($urandom()), rnd(), rnd(), rnd(), rnd(), "R7 per-cycle");
        end

        // R8: reset in mid-run
        op_mode = 2'b00; tbl_lo = '1; tbl_hi = '1;
        rst_n = 1'b0;
        @(negedge clk);
        compare('0, "R8 mid reset");
        rst_n = 1'b1;
        op(2'b00, 8'hE8, 4'h0, rnd(), rnd(), rnd(), '0, "R7 after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule